// File: doc/BRIEF.md
# Gated One-Shot Sync Distributor

This block takes a single external synchronisation input, brings it into the local clock domain and hands a qualified one-cycle pulse to each of four downstream consumers: a signal monitor, a clock divider, a numerically controlled oscillator and a decimating half-band filter. An 8-bit control register decides which consumers get the pulse. A master bit gates every path.

The divider, oscillator and half-band paths can each run in one of two modes. In continuous mode every sync edge is passed on. In one-shot mode the first delivered pulse makes the hardware clear that path's enable bit, so later sync edges are dropped until software arms the path again. The monitor path has no one-shot option.

Software reaches the control register through a synchronous write strobe with write data. The current register value is always visible on the read-data port.

Top module: `sync_fanout`

## Requirements
- R1: When control bit 0 (master) is low, no output pulse is produced, whatever the other bits hold.
- R2: The monitor output pulses for a sync edge only when bit 7 and bit 0 are both high. That path never clears itself.
- R3: The clock divider path is enabled by bit 1. When bit 2 is also high, delivering one pulse clears bit 1.
- R4: The oscillator path is enabled by bit 3. When bit 4 is also high, delivering one pulse clears bit 3, and later edges are dropped.
- R5: The half-band path is enabled by bit 5. When bit 6 is also high, delivering one pulse clears bit 5.
- R6: A path whose one-shot bit is low passes every sync edge and keeps its enable bit set.
- R7: A rising edge on `sync_in` gives a pulse exactly one cycle wide on each qualified output. The pulse is visible after the third rising clock edge that samples `sync_in` high. Holding `sync_in` high produces no further pulses.
- R8: When a write and a hardware self-clear fall on the same clock edge, the self-cleared enable bit ends at 0. Every other bit takes the written value.
- R9: Reset, synchronous and active high, clears the whole control register and all outputs.
- R10: A write loads `cfg_wdata` into the register on the next clock edge. `cfg_rdata` always reflects the current register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Current control register value |
| sync_in | input | 1 | Raw external sync, asynchronous |
| mon_sync_o | output | 1 | Qualified sync pulse to the signal monitor |
| div_sync_o | output | 1 | Qualified sync pulse to the clock divider |
| nco_sync_o | output | 1 | Qualified sync pulse to the oscillator |
| hb_sync_o | output | 1 | Qualified sync pulse to the half-band filter |

## Verification
A software write and a one-shot hardware clear can land on the same clock edge. The bench provokes this by raising `sync_in` with the divider armed in one-shot mode, then placing a register write on exactly the edge that delivers the pulse. The written value has the divider enable set and a changed pattern in the other bits. Read-back must show the divider enable cleared and every other bit equal to the written data, and the divider pulse must still be delivered once.

// File: rtl/sync_fanout_pkg.sv
package sync_fanout_pkg;

    localparam int CTRL_W  = 8;
    localparam int NUM_TGT = 4;

    // Bit positions are decoded by the gating logic and by software.
    typedef struct packed {
        logic mon_en;    // bit 7
        logic hb_once;   // bit 6
        logic hb_en;     // bit 5
        logic nco_once;  // bit 4
        logic nco_en;    // bit 3
        logic div_once;  // bit 2
        logic div_en;    // bit 1
        logic master;    // bit 0
    } sync_ctrl_t;

    typedef enum int {
        TGT_MON = 0,
        TGT_DIV = 1,
        TGT_NCO = 2,
        TGT_HB  = 3
    } sync_tgt_e;

    function automatic int en_bit(input int t);
        case (t)
            TGT_MON: return 7;
            TGT_DIV: return 1;
            TGT_NCO: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int once_bit(input int t);
        case (t)
            TGT_DIV: return 2;
            TGT_NCO: return 4;
            TGT_HB:  return 6;
            default: return 0;
        endcase
    endfunction

    function automatic bit has_once(input int t);
        return t != TGT_MON;
    endfunction

endpackage

// File: rtl/sdist_sync_edge.sv
module sdist_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    // R7: an edge indication can never last two cycles
    a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sdist_gate.sv
module sdist_gate #(
    parameter bit ONE_SHOT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic master_i,
    input  logic en_i,
    input  logic once_i,
    output logic pulse_o,
    output logic clr_o
);
    logic fire;
    logic pulse_q;

    assign fire  = edge_i & master_i & en_i;
    assign clr_o = ONE_SHOT && fire && once_i;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= fire;
    end

    assign pulse_o = pulse_q;

    // R2: every delivered pulse was qualified by master and path enable
    a_r2_pulse_qualified: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(master_i && en_i));

    // R7: delivered pulses are one cycle wide
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/sdist_ctrl_reg.sv
module sdist_ctrl_reg
    import sync_fanout_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we_i,
    input  logic [CTRL_W-1:0]   wdata_i,
    input  logic [NUM_TGT-1:0]  clr_i,
    output logic [CTRL_W-1:0]   q_o
);
    logic [CTRL_W-1:0] q_r;
    logic [CTRL_W-1:0] nxt;

    always_comb begin
        nxt = we_i ? wdata_i : q_r;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (clr_i[t]) nxt[en_bit(t)] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= nxt;
    end

    assign q_o = q_r;

    // R9: reset empties the register
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (q_o == '0));

    // R10: a write with no concurrent self-clear lands unchanged
    a_r10_write_load: assert property (@(posedge clk) disable iff (rst)
        (we_i && clr_i == '0) |=> (q_o == $past(wdata_i)));

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_chk
        // R8: a self-clear wins over any write in the same cycle
        a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
            clr_i[t] |=> !q_o[en_bit(t)]);
    end
endmodule

// File: rtl/sync_fanout.sv
module sync_fanout
    import sync_fanout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              sync_in,
    output logic              mon_sync_o,
    output logic              div_sync_o,
    output logic              nco_sync_o,
    output logic              hb_sync_o
);
    logic [CTRL_W-1:0]  ctrl_bits;
    sync_ctrl_t         ctrl;
    logic               sync_rise;
    logic [NUM_TGT-1:0] pulse;
    logic [NUM_TGT-1:0] clr;

    sdist_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_i (sync_in),
        .rise_o  (sync_rise)
    );

    sdist_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .clr_i   (clr),
        .q_o     (ctrl_bits)
    );

    assign ctrl = sync_ctrl_t'(ctrl_bits);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        sdist_gate #(.ONE_SHOT(has_once(t))) u_gate (
            .clk      (clk),
            .rst      (rst),
            .edge_i   (sync_rise),
            .master_i (ctrl.master),
            .en_i     (ctrl_bits[en_bit(t)]),
            .once_i   (ctrl_bits[once_bit(t)]),
            .pulse_o  (pulse[t]),
            .clr_o    (clr[t])
        );
    end

    assign cfg_rdata  = ctrl_bits;
    assign mon_sync_o = pulse[TGT_MON];
    assign div_sync_o = pulse[TGT_DIV];
    assign nco_sync_o = pulse[TGT_NCO];
    assign hb_sync_o  = pulse[TGT_HB];

    // R1: with master low nothing leaves the block on the next cycle
    a_r1_master_gate: assert property (@(posedge clk) disable iff (rst)
        !ctrl.master |=> (pulse == '0));

    // R2: the monitor path never requests a self-clear
    a_r2_mon_no_clear: assert property (@(posedge clk) disable iff (rst)
        !clr[TGT_MON]);
endmodule

// File: tb/tb_sync_fanout.sv
module tb_sync_fanout;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sync_in = 1'b0;
    logic       mon_sync_o, div_sync_o, nco_sync_o, hb_sync_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int       due;
        logic [3:0] exp;
        string    tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_fanout dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sync_in(sync_in),
        .mon_sync_o(mon_sync_o), .div_sync_o(div_sync_o),
        .nco_sync_o(nco_sync_o), .hb_sync_o(hb_sync_o)
    );

    function automatic logic [3:0] outs();
        return {hb_sync_o, nco_sync_o, div_sync_o, mon_sync_o};
    endfunction

    // Monitor: compares each cycle against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                checks++;
                if (outs() !== q[0].exp) begin
                    fails++;
                    $display("FAIL %s: pulses actual %b expected %b", q[0].tag, outs(), q[0].exp);
                end
                void'(q.pop_front());
            end else if (outs() !== 4'b0) begin
                checks++;
                fails++;
                $display("FAIL R7: stray pulses actual %b expected 0000", outs());
            end
        end
    end

    task automatic check_reg(input logic [7:0] exp, input string tag);
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: cfg_rdata actual %h expected %h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected pulse vector {hb,nco,div,mon} for a register value.
    function automatic logic [3:0] gate_of(input logic [7:0] v);
        return v[0] ? {v[5], v[3], v[1], v[7]} : 4'b0;
    endfunction

    function automatic logic [7:0] after_of(input logic [7:0] v);
        logic [7:0] r = v;
        if (v[0] && v[1] && v[2]) r[1] = 1'b0;
        if (v[0] && v[3] && v[4]) r[3] = 1'b0;
        if (v[0] && v[5] && v[6]) r[5] = 1'b0;
        return r;
    endfunction

    // Driver: raise sync, push the expected pulse set three edges later.
    task automatic fire(input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        sync_in = 1'b1;
        it.due = cyc + 3; it.exp = exp; it.tag = tag;
        q.push_back(it);
        repeat (4) @(negedge clk);
        sync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reg(8'h00, "R9 reset state");
        fire(4'b0000, "R9 no sync after reset");

        // R1/R2/R3/R4/R5: every register value, gating and self-clear
        for (int v = 0; v < 256; v++) begin
            wr(v[7:0]);
            check_reg(v[7:0], "R10 readback");
            fire(gate_of(v[7:0]), v[0] ? "R2 R3 R4 R5 gating" : "R1 master off");
            check_reg(after_of(v[7:0]), "R3 R4 R5 self-clear");
        end

        // R6: continuous divider passes every edge
        wr(8'h03);
        for (int k = 0; k < 3; k++) fire(4'b0010, "R6 continuous divider");
        check_reg(8'h03, "R6 enable kept");
        // R2: monitor continuous
        wr(8'h81);
        fire(4'b0001, "R2 monitor");
        fire(4'b0001, "R2 monitor repeat");
        check_reg(8'h81, "R2 monitor not cleared");

        // R4: oscillator one-shot, second edge dropped
        wr(8'h19);
        fire(4'b0100, "R4 first edge");
        fire(4'b0000, "R4 later edge ignored");
        check_reg(8'h11, "R4 enable cleared");
        // R5: half-band one-shot then re-arm
        wr(8'h61);
        fire(4'b1000, "R5 first edge");
        fire(4'b0000, "R5 later edge ignored");
        wr(8'h61);
        fire(4'b1000, "R5 re-armed");

        // R8: write on the edge that self-clears the divider
        wr(8'h07);
        begin
            item_t it;
            @(negedge clk);
            sync_in = 1'b1;
            it.due = cyc + 3; it.exp = 4'b0010; it.tag = "R8 pulse still delivered";
            q.push_back(it);
            @(negedge clk);
            @(negedge clk);
            cfg_we = 1'b1; cfg_wdata = 8'hAF;
            @(negedge clk);
            cfg_we = 1'b0;
            check_reg(8'hAD, "R8 clear wins over write");
            repeat (2) @(negedge clk);
            sync_in = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R9: reset mid-run clears everything
        wr(8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_reg(8'h00, "R9 reset clears register");
        fire(4'b0000, "R9 no pulses after reset");

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule